// File: doc/BRIEF.md
# Segment Selector Decoder and Access Checker

This block stands at the head of an address path. Each request carries a 16-bit segment selector, a 32-bit offset and an access kind (read, write or instruction fetch). The selector names one descriptor in one of two small on-chip tables: a global table or a local table. The block then checks that the segment is present, that the access kind is allowed by the descriptor type, and that the offset lies inside the segment. One cycle after the request it returns either a 32-bit linear address or a fault with a 2-bit code. The requester protection level in the selector is carried through to the output but not compared against anything.

Both tables are register arrays. A host fills them one descriptor at a time through a write port that names the table and the slot. Every descriptor has a 32-bit base, a 20-bit size field and a granularity flag. The granularity flag scales the size field to 4 KiB units. A descriptor also has an application/system flag, a code/data flag, one permission bit and a present flag. Reset marks every slot as absent.

Top module: `seg_xlate`

## Requirements
- R1: The request selector is split as index = bits 15:3, table choice = bit 2 (0 global, 1 local) and requester level = bits 1:0. The requester level appears on `out_rpl` with the result. `out_rpl` is 0 in a cycle with no result.
- R2: A write with `wr_en` high stores the descriptor fields into slot `wr_slot` of the global table (`wr_ldt`=0) or the local table (`wr_ldt`=1) at the clock edge. A later request sees the new contents. Reset marks every slot of both tables absent.
- R3: A request with `req_valid` high produces exactly one of `out_valid` or `out_fault` on the next cycle. A cycle without a request produces neither in the following cycle.
- R4: An index at or beyond the depth of the chosen table (default 8 global, 4 local) faults with code 0.
- R5: A descriptor whose present flag is clear faults with code 1.
- R6: A descriptor with the application flag clear (a system descriptor) faults with code 2. The access kinds are encoded 00 read, 01 write, 10 fetch. Kind 11 is reserved and faults with code 2.
- R7: For a data descriptor (code flag 0), permission 1 allows read and write and permission 0 allows read only. A write to a read-only data segment faults with code 2, and so does a fetch from any data segment.
- R8: For a code descriptor (code flag 1), fetch is always allowed and write always faults with code 2. Read is allowed only with permission 1; otherwise it faults with code 2.
- R9: The effective limit is the zero-extended 20-bit size field when granularity is 0, and {size, 12'hFFF} when granularity is 1. An offset equal to the effective limit is accepted. An offset above it faults with code 3.
- R10: When several faults apply, the reported code follows the priority index (0) > absent (1) > permission (2) > limit (3).
- R11: On success `out_lin` = base + offset modulo 2^32, with `out_valid` high and `out_fault` low. On a fault `out_valid` is low and `out_lin` is 0.
- R12: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Descriptor write strobe |
| wr_ldt | input | 1 | Write target: 0 global table, 1 local table |
| wr_slot | input | SLOT_W (3) | Slot written |
| wr_base | input | 32 | Segment base |
| wr_limit | input | 20 | Segment size field |
| wr_gran | input | 1 | Size field in 4 KiB units |
| wr_app | input | 1 | 1 = code/data descriptor, 0 = system descriptor |
| wr_code | input | 1 | 1 = code segment, 0 = data segment |
| wr_perm | input | 1 | Data: writable; code: readable |
| wr_present | input | 1 | Segment present |
| req_valid | input | 1 | Request strobe |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset within the segment |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 reserved |
| out_valid | output | 1 | Linear address valid |
| out_lin | output | 32 | Linear address |
| out_rpl | output | 2 | Requester level carried from the selector |
| out_fault | output | 1 | Fault strobe |
| out_fcode | output | 2 | Fault code (valid with `out_fault`) |

## Verification
The bound checker watches the port-level contract on every cycle. It checks that each request produces exactly one of result or fault one cycle later and nothing without a request, and that result and fault never coincide. It checks that a faulting cycle returns a zero address, that the requester level tracks the selector, and that an out-of-range index always yields code 0. Fault decisions that depend on table contents can only be shown by the bench's scenarios. These cover the per-type permission matrix, the limit boundaries under both granularities, address wrap-around, the fault priority, and the effect of table rewrites and reset.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   localparam int LIN_W     = 32;
   localparam int SIZE_W    = 20;
   localparam int SEL_W     = 16;
   localparam int IDX_W     = 13;
   localparam int IDX_LSB   = 3;
   localparam int TI_BIT    = 2;
   localparam int RPL_W     = 2;
   localparam int GRAN_SH   = LIN_W - SIZE_W;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RSVD  = 2'b11
   } seg_acc_e;

   typedef enum logic [1:0] {
      FLT_INDEX  = 2'd0,
      FLT_ABSENT = 2'd1,
      FLT_PERM   = 2'd2,
      FLT_LIMIT  = 2'd3
   } seg_flt_e;

   typedef struct packed {
      logic [LIN_W-1:0]  base;
      logic [SIZE_W-1:0] size;
      logic              gran;
      logic              app;
      logic              code;
      logic              perm;
      logic              present;
   } seg_desc_t;

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
   import seg_xlate_pkg::*;
(
   input  logic [SEL_W-1:0] sel,
   output logic [IDX_W-1:0] idx,
   output logic             ti,
   output logic [RPL_W-1:0] rpl
);

   if (IDX_LSB + IDX_W != SEL_W) begin : g_bad_layout
      $error("seg_sel_decode: index field does not reach the selector top");
   end
   if (TI_BIT + 1 != IDX_LSB || RPL_W != TI_BIT) begin : g_bad_fields
      $error("seg_sel_decode: selector fields overlap or leave gaps");
   end

   always_comb begin
      idx = sel[SEL_W-1:IDX_LSB];
      ti  = sel[TI_BIT];
      rpl = sel[RPL_W-1:0];
   end

endmodule

// File: rtl/seg_desc_table.sv
module seg_desc_table
   import seg_xlate_pkg::*;
#(
   parameter int DEPTH         = 8,
   parameter int SLOT_W        = 3,
   parameter bit RESET_PAYLOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  seg_desc_t         wr_desc,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_hit,
   output seg_desc_t         rd_desc
);

   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || DEPTH > (1 << IDX_W)) begin : g_bad_depth
      $error("seg_desc_table: DEPTH must lie in 2 .. 2**IDX_W");
   end
   if (SLOT_W < AW) begin : g_bad_slot
      $error("seg_desc_table: SLOT_W too narrow for DEPTH");
   end

   logic [DEPTH-1:0] present_q;
   seg_desc_t        body_q [DEPTH];
   logic             wr_ok;
   logic [AW-1:0]    wr_a;
   logic [AW-1:0]    rd_a;

   assign wr_ok = wr_en && (32'(wr_slot) < DEPTH);
   assign wr_a  = wr_slot[AW-1:0];
   assign rd_a  = rd_idx[AW-1:0];

   // Present flags always reset so a fresh table reports absent slots.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         present_q <= '0;
      end else if (wr_ok) begin
         present_q[wr_a] <= wr_desc.present;
      end
   end

   if (RESET_PAYLOAD) begin : g_body_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) body_q[i] <= '0;
         end else if (wr_ok) begin
            body_q[wr_a] <= wr_desc;
         end
      end
   end else begin : g_body_plain
      always_ff @(posedge clk) begin
         if (wr_ok) body_q[wr_a] <= wr_desc;
      end
   end

   always_comb begin
      rd_hit  = (32'(rd_idx) < DEPTH);
      rd_desc = '0;
      if (rd_hit) begin
         rd_desc         = body_q[rd_a];
         rd_desc.present = present_q[rd_a];
      end
   end

endmodule

// File: rtl/seg_rule_check.sv
module seg_rule_check
   import seg_xlate_pkg::*;
(
   input  logic             hit,
   input  seg_desc_t        desc,
   input  logic [1:0]       kind,
   input  logic [LIN_W-1:0] off,
   output logic             fault,
   output logic [1:0]       fcode,
   output logic [LIN_W-1:0] lin
);

   seg_acc_e         acc;
   logic             perm_bad;
   logic             over;
   logic [LIN_W-1:0] eff_limit;

   assign acc = seg_acc_e'(kind);

   always_comb begin
      if (desc.gran) eff_limit = {desc.size, {GRAN_SH{1'b1}}};
      else           eff_limit = LIN_W'(desc.size);
      over = (off > eff_limit);
   end

   always_comb begin
      perm_bad = 1'b0;
      if (!desc.app) begin
         perm_bad = 1'b1;
      end else if (desc.code) begin
         unique case (acc)
            ACC_FETCH: perm_bad = 1'b0;
            ACC_READ:  perm_bad = !desc.perm;
            ACC_WRITE: perm_bad = 1'b1;
            default:   perm_bad = 1'b1;
         endcase
      end else begin
         unique case (acc)
            ACC_READ:  perm_bad = 1'b0;
            ACC_WRITE: perm_bad = !desc.perm;
            ACC_FETCH: perm_bad = 1'b1;
            default:   perm_bad = 1'b1;
         endcase
      end
   end

   always_comb begin
      fault = 1'b1;
      fcode = FLT_INDEX;
      if (!hit)               fcode = FLT_INDEX;
      else if (!desc.present) fcode = FLT_ABSENT;
      else if (perm_bad)      fcode = FLT_PERM;
      else if (over)          fcode = FLT_LIMIT;
      else begin
         fault = 1'b0;
         fcode = FLT_INDEX;
      end
      lin = desc.base + off;
   end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int GDT_DEPTH     = 8,
   parameter int LDT_DEPTH     = 4,
   parameter bit RESET_PAYLOAD = 1'b1,
   parameter int SLOT_W        = $clog2((GDT_DEPTH > LDT_DEPTH) ? GDT_DEPTH : LDT_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_ldt,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [31:0]       wr_base,
   input  logic [19:0]       wr_limit,
   input  logic              wr_gran,
   input  logic              wr_app,
   input  logic              wr_code,
   input  logic              wr_perm,
   input  logic              wr_present,
   input  logic              req_valid,
   input  logic [15:0]       req_sel,
   input  logic [31:0]       req_off,
   input  logic [1:0]        req_kind,
   output logic              out_valid,
   output logic [31:0]       out_lin,
   output logic [1:0]        out_rpl,
   output logic              out_fault,
   output logic [1:0]        out_fcode
);

   localparam int NTAB = 2;

   if (LIN_W != 32 || SIZE_W != 20 || SEL_W != 16) begin : g_bad_pkg
      $error("seg_xlate: port widths disagree with the package");
   end

   seg_desc_t        wdesc;
   logic [IDX_W-1:0] idx;
   logic             ti;
   logic [RPL_W-1:0] rpl;
   logic [NTAB-1:0]  t_hit;
   seg_desc_t        t_desc [NTAB];
   logic             sel_hit;
   seg_desc_t        sel_desc;
   logic             c_fault;
   logic [1:0]       c_code;
   logic [LIN_W-1:0] c_lin;

   assign wdesc = '{base: wr_base, size: wr_limit, gran: wr_gran, app: wr_app,
                    code: wr_code, perm: wr_perm, present: wr_present};

   seg_sel_decode u_dec (
      .sel (req_sel),
      .idx (idx),
      .ti  (ti),
      .rpl (rpl)
   );

   for (genvar t = 0; t < NTAB; t++) begin : g_tab
      localparam int DEP = (t == 0) ? GDT_DEPTH : LDT_DEPTH;
      logic t_we;
      assign t_we = wr_en && (wr_ldt == 1'(t));
      seg_desc_table #(
         .DEPTH         (DEP),
         .SLOT_W        (SLOT_W),
         .RESET_PAYLOAD (RESET_PAYLOAD)
      ) u_tab (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (t_we),
         .wr_slot (wr_slot),
         .wr_desc (wdesc),
         .rd_idx  (idx),
         .rd_hit  (t_hit[t]),
         .rd_desc (t_desc[t])
      );
   end

   always_comb begin
      sel_hit  = ti ? t_hit[1]  : t_hit[0];
      sel_desc = ti ? t_desc[1] : t_desc[0];
   end

   seg_rule_check u_chk (
      .hit   (sel_hit),
      .desc  (sel_desc),
      .kind  (req_kind),
      .off   (req_off),
      .fault (c_fault),
      .fcode (c_code),
      .lin   (c_lin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_fault <= 1'b0;
         out_fcode <= '0;
         out_lin   <= '0;
         out_rpl   <= '0;
      end else begin
         out_valid <= req_valid && !c_fault;
         out_fault <= req_valid && c_fault;
         out_fcode <= (req_valid && c_fault) ? c_code : 2'd0;
         out_lin   <= (req_valid && !c_fault) ? c_lin : '0;
         out_rpl   <= req_valid ? rpl : '0;
      end
   end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int GDT_DEPTH = 8,
   parameter int LDT_DEPTH = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [15:0] req_sel,
   input logic        out_valid,
   input logic [31:0] out_lin,
   input logic [1:0]  out_rpl,
   input logic        out_fault,
   input logic [1:0]  out_fcode
);

   logic bad_idx;
   assign bad_idx = req_sel[2] ? (32'(req_sel[15:3]) >= LDT_DEPTH)
                               : (32'(req_sel[15:3]) >= GDT_DEPTH);

   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && out_fault)); // R3

   AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (out_valid || out_fault)); // R3

   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(out_valid || out_fault)); // R3

   AST_RPL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (out_rpl == $past(req_sel[1:0]))); // R1

   AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      out_fault |-> (out_lin == 32'd0)); // R11

   AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && bad_idx) |=> (out_fault && out_fcode == 2'd0)); // R4

endmodule

bind seg_xlate seg_xlate_chk #(.GDT_DEPTH(GDT_DEPTH), .LDT_DEPTH(LDT_DEPTH)) u_seg_xlate_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_sel   (req_sel),
   .out_valid (out_valid),
   .out_lin   (out_lin),
   .out_rpl   (out_rpl),
   .out_fault (out_fault),
   .out_fcode (out_fcode)
);

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en, wr_ldt;
   logic [2:0]  wr_slot;
   logic [31:0] wr_base;
   logic [19:0] wr_limit;
   logic        wr_gran, wr_app, wr_code, wr_perm, wr_present;
   logic        req_valid;
   logic [15:0] req_sel;
   logic [31:0] req_off;
   logic [1:0]  req_kind;
   logic        out_valid, out_fault;
   logic [31:0] out_lin;
   logic [1:0]  out_rpl, out_fcode;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   seg_xlate dut (.*);

   typedef struct packed {
      logic [3:0]  rq;
      logic [15:0] sel;
      logic [31:0] off;
      logic [1:0]  kind;
      logic        flt;
      logic [1:0]  code;
      logic [31:0] lin;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VEC [NV] = '{
      '{4'd11, 16'h0000, 32'h0000_0010, 2'b00, 1'b0, 2'd0, 32'h1000_0010}, // R11 R7 read
      '{4'd9,  16'h0003, 32'h0000_0FFF, 2'b01, 1'b0, 2'd0, 32'h1000_0FFF}, // R9 at limit
      '{4'd9,  16'h0000, 32'h0000_1000, 2'b00, 1'b1, 2'd3, 32'h0},         // R9 past limit
      '{4'd7,  16'h0001, 32'h0000_0000, 2'b10, 1'b1, 2'd2, 32'h0},         // R7 fetch data
      '{4'd9,  16'h0008, 32'h0001_0FFF, 2'b00, 1'b0, 2'd0, 32'h0003_0FFF}, // R9 gran limit
      '{4'd9,  16'h0008, 32'h0001_1000, 2'b00, 1'b1, 2'd3, 32'h0},         // R9 gran over
      '{4'd7,  16'h0008, 32'h0000_0000, 2'b01, 1'b1, 2'd2, 32'h0},         // R7 write RO
      '{4'd8,  16'h0012, 32'h0000_1234, 2'b10, 1'b0, 2'd0, 32'h4000_1234}, // R8 fetch
      '{4'd8,  16'h0010, 32'h0000_0000, 2'b00, 1'b1, 2'd2, 32'h0},         // R8 read x-only
      '{4'd8,  16'h0018, 32'h0000_0100, 2'b00, 1'b0, 2'd0, 32'h0000_0100}, // R8 read x/r
      '{4'd8,  16'h0018, 32'h0000_0000, 2'b01, 1'b1, 2'd2, 32'h0},         // R8 write code
      '{4'd5,  16'h0020, 32'h0000_0000, 2'b00, 1'b1, 2'd1, 32'h0},         // R5 absent
      '{4'd6,  16'h0028, 32'h0000_0000, 2'b00, 1'b1, 2'd2, 32'h0},         // R6 system
      '{4'd11, 16'h0032, 32'h0000_1800, 2'b00, 1'b0, 2'd0, 32'h0000_0800}, // R11 wrap
      '{4'd1,  16'h0007, 32'h0000_0080, 2'b01, 1'b0, 2'd0, 32'h8000_0080}, // R1 local
      '{4'd2,  16'h000C, 32'h0000_0000, 2'b00, 1'b1, 2'd1, 32'h0},         // R2 unloaded
      '{4'd4,  16'h0024, 32'h0000_0000, 2'b00, 1'b1, 2'd0, 32'h0},         // R4 local range
      '{4'd4,  16'h0040, 32'h0000_0000, 2'b00, 1'b1, 2'd0, 32'h0},         // R4 global range
      '{4'd4,  16'hFFF9, 32'h0000_0000, 2'b00, 1'b1, 2'd0, 32'h0},         // R4 top index
      '{4'd6,  16'h0000, 32'h0000_0000, 2'b11, 1'b1, 2'd2, 32'h0},         // R6 reserved kind
      '{4'd10, 16'h0020, 32'hFFFF_FFFF, 2'b10, 1'b1, 2'd1, 32'h0},         // R10 absent first
      '{4'd10, 16'h0028, 32'h0000_0010, 2'b00, 1'b1, 2'd2, 32'h0},         // R10 perm first
      '{4'd10, 16'h0008, 32'h0002_0000, 2'b01, 1'b1, 2'd2, 32'h0}          // R10 perm over limit
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic load(input logic ldt, input logic [2:0] slot, input logic [31:0] base,
                       input logic [19:0] lim, input logic g, input logic a,
                       input logic c, input logic p, input logic pr);
      @(negedge clk);
      wr_en = 1'b1; wr_ldt = ldt; wr_slot = slot; wr_base = base; wr_limit = lim;
      wr_gran = g; wr_app = a; wr_code = c; wr_perm = p; wr_present = pr;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Drive one request at a falling edge, sample just after the next rising edge.
   task automatic ask(input logic [15:0] sel, input logic [31:0] off, input logic [1:0] kind);
      @(negedge clk);
      req_valid = 1'b1; req_sel = sel; req_off = off; req_kind = kind;
      @(posedge clk);
      #1;
   endtask

   function automatic logic [63:0] pack_out();
      return {25'd0, out_valid, out_fault, out_fcode, out_rpl, out_lin};
   endfunction

   function automatic logic [63:0] pack_exp(input logic flt, input logic [1:0] code,
                                            input logic [1:0] rpl, input logic [31:0] lin);
      return {25'd0, !flt, flt, flt ? code : 2'd0, rpl, flt ? 32'd0 : lin};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_ldt = 1'b0; wr_slot = '0; wr_base = '0;
      wr_limit = '0; wr_gran = 1'b0; wr_app = 1'b0; wr_code = 1'b0; wr_perm = 1'b0;
      wr_present = 1'b0; req_valid = 1'b0; req_sel = '0; req_off = '0; req_kind = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R12 reset outputs", pack_out(), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // Global slots 0..6, local slot 0.
      load(1'b0, 3'd0, 32'h1000_0000, 20'h00FFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
      load(1'b0, 3'd1, 32'h0002_0000, 20'h00010, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
      load(1'b0, 3'd2, 32'h4000_0000, 20'hFFFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
      load(1'b0, 3'd3, 32'h0000_0000, 20'h00100, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
      load(1'b0, 3'd4, 32'h0500_0000, 20'h00FFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
      load(1'b0, 3'd5, 32'h0600_0000, 20'h00000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      load(1'b0, 3'd6, 32'hFFFF_F000, 20'h01FFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
      load(1'b1, 3'd0, 32'h8000_0000, 20'h000FF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);

      // Back-to-back walk of the vector table.
      for (int i = 0; i < NV; i++) begin
         ask(VEC[i].sel, VEC[i].off, VEC[i].kind);
         chk($sformatf("R%0d vector %0d", VEC[i].rq, i), pack_out(),
             pack_exp(VEC[i].flt, VEC[i].code, VEC[i].sel[1:0], VEC[i].lin));
      end

      // R3: no request, no outcome on the next cycle.
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk);
      #1;
      chk("R3 idle", pack_out(), 64'd0);

      // R2: rewrite local slot 0, the next request uses the new base.
      load(1'b1, 3'd0, 32'h0123_0000, 20'h000FF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      ask(16'h0004, 32'h0000_0010, 2'b00);
      chk("R2 rewrite base", pack_out(), pack_exp(1'b0, 2'd0, 2'd0, 32'h0123_0010));
      ask(16'h0004, 32'h0000_0010, 2'b01);
      chk("R2 rewrite perm", pack_out(), pack_exp(1'b1, 2'd2, 2'd0, 32'h0));

      // R2: mark global 0 absent through the write port.
      load(1'b0, 3'd0, 32'h1000_0000, 20'h00FFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
      ask(16'h0000, 32'h0, 2'b00);
      chk("R2 cleared present", pack_out(), pack_exp(1'b1, 2'd1, 2'd0, 32'h0));

      // R12 / R2: reset while requesting, then previously present slot is absent.
      @(negedge clk);
      req_valid = 1'b1; req_sel = 16'h0018; req_kind = 2'b10; req_off = 32'h0;
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      chk("R12 reset mid-run", pack_out(), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R2 reset clears tables", pack_out(), pack_exp(1'b1, 2'd1, 2'd0, 32'h0));

      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule